// File: doc/BRIEF.md
# MSI Interrupt Message Generator

This block gathers a wide set of edge-triggered interrupt inputs (DMA completion and DMA overflow per channel, audio/video, two serial-bus controllers, one unmapped-traffic-class event and sixteen general-purpose pins, fifty in all by default) and turns them into message-signalled interrupt write requests. Each input has its own active-edge select and its own enable bit. A detected edge sets a sticky status bit. Enabled, pending sources are picked by a round-robin arbiter, and each pick becomes one write request carrying an address, a data word and a traffic class.

Software sets everything up through a 32-bit register port with a 4 KB, word-aligned window. It programs a destination address whose three low bits hold the traffic class, a base data word, the allocated vector count as a power of two, and a hold-off delay between messages. The number of vectors requested defaults to 32. Boot logic may lower it, but only before the first register write. The message data is the base word with its low bits replaced by the source number folded into the allocated count. When messaging is switched off, a legacy level interrupt output can stand in for the messages.

The message output is a valid/ready stream. Once `msg_valid_o` is high it stays high, and address, data and traffic class stay fixed, until a cycle in which `msg_ready_i` is high. Only one message is outstanding at any time. Status clears in the cycle the message is accepted, and a consumer that holds ready low stalls all further messages.

Top module: `msi_irq_gen`

## Requirements
- R1: After reset, `msg_valid_o` and `inta_o` are 0. The control word (word address 0x000) reads 0x500: bit 0 is the message enable (0), bits 6:4 are the allocated log2 count (0), and bits 10:8 are the requested log2 count (5). Status and enable words read 0.
- R2: Status word w sits at byte address 0x040+4w and holds sources 32w..32w+31. The polarity word sits at 0x0C0+4w. A polarity bit of 0 makes a rising edge set the status bit, and 1 makes a falling edge set it. The other edge has no effect.
- R3: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new active edge arrives in the same cycle as the clearing write, the bit stays set.
- R4: A source whose enable bit is 0 (enable word at 0x080+4w) still sets its status bit but produces no message. Once it is enabled while still pending, a message is sent.
- R5: Messages are issued only while control bit 0 is 1. A message carries address = the address register (0x004) with bits 2:0 forced to 0, traffic class = address register bits 2:0, and data = the data register (0x008) with its low E bits replaced by the source index modulo 2^E. Here E = min(allocated, requested). The served source's status bit clears on acceptance.
- R6: While `msg_valid_o` is high and `msg_ready_i` is low, valid stays high and address, data and traffic class stay stable.
- R7: Among pending enabled sources, the arbiter picks the lowest index above the last served index, wrapping to the lowest index overall. After reset, the last served index counts as the highest source.
- R8: With delay register (0x00C) value D, a message accepted at one clock edge is followed by the next message no earlier than the (D+1)-th following edge. If a source is pending, the next message appears at exactly that edge.
- R9: While control bit 0 is 0, `inta_o` is high exactly when some status bit with its enable bit set is 1. While control bit 0 is 1, `inta_o` is 0.
- R10: A boot request before the first register write sets the requested log2 count, clamped to 5. After any register write, boot requests are ignored.
- R11: Address bits 1:0 are ignored. Reads from unmapped word addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NUM_SRC | Edge-triggered interrupt sources |
| boot_set_i | input | 1 | Boot-time strobe to load the requested vector count |
| boot_log2_i | input | 3 | Requested count as log2 (0..5) |
| mmio_we_i | input | 1 | Register write strobe |
| mmio_addr_i | input | 12 | Register byte address |
| mmio_wdata_i | input | 32 | Register write data |
| mmio_rdata_o | output | 32 | Register read data for `mmio_addr_i` |
| msg_valid_o | output | 1 | Message write request valid |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_addr_o | output | 32 | Message destination address |
| msg_data_o | output | 32 | Message data with folded vector |
| msg_tc_o | output | 3 | Message traffic class |
| inta_o | output | 1 | Legacy level interrupt emulation |

## Verification
A wrong arbiter pointer shows as a message out of order. This appears in the data low bits of the second message after a multi-source burst, within a few cycles. A status bit wrongly kept or lost shows either as an extra message or a level interrupt that stays high, or as a source that never produces a message. Reading the status word through the register port exposes it in the next read. An off-by-one in the delay counter moves the second message of a pair by one cycle and is measured exactly. A failure to freeze the requested count shows in the control word and in how many data bits the next message folds.

// File: rtl/msi_pkg.sv
package msi_pkg;
  // Width of all log2 vector-count fields
  localparam int unsigned LOG_W = 3;

  // Register word addresses (byte address bits 11:2)
  typedef logic [9:0] word_addr_t;
  localparam word_addr_t WA_CTRL   = 10'h000;
  localparam word_addr_t WA_ADDR   = 10'h001;
  localparam word_addr_t WA_DATA   = 10'h002;
  localparam word_addr_t WA_GAP    = 10'h003;
  localparam word_addr_t WA_STATUS = 10'h010;
  localparam word_addr_t WA_ENABLE = 10'h020;
  localparam word_addr_t WA_POLAR  = 10'h030;

  typedef enum logic [1:0] {EM_IDLE, EM_SEND, EM_HOLD} em_state_t;
endpackage

// File: rtl/msi_src_bank.sv
module msi_src_bank #(
  parameter int NUM_SRC = 50,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] polar_i,
  input  logic [NUM_SRC-1:0] w1c_i,
  input  logic               srv_clr_i,
  input  logic [IDX_W-1:0]   srv_idx_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic               primed;
  logic [NUM_SRC-1:0] prev_q;

  // Sample history; first cycle after reset only primes the history
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0;
      prev_q <= '0;
    end else begin
      primed <= 1'b1;
      prev_q <= src_i;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic edge_hit;
    logic served;
    logic bit_q;

    assign edge_hit = primed & (polar_i[g] ? (prev_q[g] & ~src_i[g])
                                           : (~prev_q[g] & src_i[g]));
    assign served   = srv_clr_i && (srv_idx_i == IDX_W'(g));

    // A fresh edge wins over any clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= edge_hit | (bit_q & ~w1c_i[g] & ~served);
    end

    assign status_o[g] = bit_q;
  end
endmodule

// File: rtl/msi_rr_arb.sv
module msi_rr_arb #(
  parameter int NUM_SRC = 50,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               adv_i,
  input  logic [IDX_W-1:0]   adv_idx_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   pick_o
);
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] pick_hi, pick_lo;
  logic             found_hi;

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= IDX_W'(NUM_SRC - 1);
    else if (adv_i) last_q <= adv_idx_i;
  end

  // Descending scans leave the lowest qualifying index in each result
  always_comb begin
    pick_hi  = '0;
    pick_lo  = '0;
    found_hi = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick_lo = IDX_W'(i);
        if (IDX_W'(i) > last_q) begin
          pick_hi  = IDX_W'(i);
          found_hi = 1'b1;
        end
      end
    end
  end

  assign any_o  = |req_i;
  assign pick_o = found_hi ? pick_hi : pick_lo;
endmodule

// File: rtl/msi_csr.sv
module msi_csr
  import msi_pkg::*;
#(
  parameter int NUM_SRC  = 50,
  parameter int DELAY_W  = 16,
  parameter int MAX_LOG2 = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_set_i,
  input  logic [LOG_W-1:0]   boot_log2_i,
  input  logic               mmio_we_i,
  input  logic [11:0]        mmio_addr_i,
  input  logic [31:0]        mmio_wdata_i,
  output logic [31:0]        mmio_rdata_o,
  input  logic [NUM_SRC-1:0] status_i,
  output logic               msg_on_o,
  output logic               locked_o,
  output logic [LOG_W-1:0]   req_log2_o,
  output logic [LOG_W-1:0]   eff_log2_o,
  output logic [31:0]        base_addr_o,
  output logic [31:0]        base_data_o,
  output logic [DELAY_W-1:0] gap_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [NUM_SRC-1:0] polar_o,
  output logic [NUM_SRC-1:0] w1c_o
);
  localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W     = NUM_WORDS * 32;
  localparam logic [LOG_W-1:0] MAX_L = LOG_W'(MAX_LOG2);

  word_addr_t         waddr;
  logic               msg_on_q, locked_q;
  logic [LOG_W-1:0]   alloc_q, req_q, boot_clamped;
  logic [31:0]        addr_q, data_q;
  logic [DELAY_W-1:0] gap_q;
  logic [NUM_SRC-1:0] en_q, pol_q;
  logic [PAD_W-1:0]   st_pad, en_pad, pol_pad;

  assign waddr        = mmio_addr_i[11:2];
  assign boot_clamped = (boot_log2_i > MAX_L) ? MAX_L : boot_log2_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_on_q <= 1'b0;
      locked_q <= 1'b0;
      alloc_q  <= '0;
      req_q    <= MAX_L;
      addr_q   <= '0;
      data_q   <= '0;
      gap_q    <= '0;
      en_q     <= '0;
      pol_q    <= '0;
    end else begin
      if (boot_set_i && !locked_q) req_q <= boot_clamped;
      if (mmio_we_i) begin
        locked_q <= 1'b1;
        case (waddr)
          WA_CTRL: begin
            msg_on_q <= mmio_wdata_i[0];
            alloc_q  <= mmio_wdata_i[4 +: LOG_W];
          end
          WA_ADDR: addr_q <= mmio_wdata_i;
          WA_DATA: data_q <= mmio_wdata_i;
          WA_GAP:  gap_q  <= mmio_wdata_i[DELAY_W-1:0];
          default: ;
        endcase
        for (int i = 0; i < NUM_SRC; i++) begin
          if (waddr == WA_ENABLE + 10'(i / 32)) en_q[i]  <= mmio_wdata_i[i % 32];
          if (waddr == WA_POLAR + 10'(i / 32))  pol_q[i] <= mmio_wdata_i[i % 32];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      w1c_o[i] = mmio_we_i && (waddr == WA_STATUS + 10'(i / 32)) && mmio_wdata_i[i % 32];
    end
  end

  always_comb begin
    st_pad  = '0;
    en_pad  = '0;
    pol_pad = '0;
    st_pad[NUM_SRC-1:0]  = status_i;
    en_pad[NUM_SRC-1:0]  = en_q;
    pol_pad[NUM_SRC-1:0] = pol_q;
    mmio_rdata_o = '0;
    if (waddr == WA_CTRL) begin
      mmio_rdata_o[0]            = msg_on_q;
      mmio_rdata_o[4 +: LOG_W]   = alloc_q;
      mmio_rdata_o[8 +: LOG_W]   = req_q;
    end
    if (waddr == WA_ADDR) mmio_rdata_o = addr_q;
    if (waddr == WA_DATA) mmio_rdata_o = data_q;
    if (waddr == WA_GAP)  mmio_rdata_o[DELAY_W-1:0] = gap_q;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (waddr == WA_STATUS + 10'(w)) mmio_rdata_o = st_pad[w*32 +: 32];
      if (waddr == WA_ENABLE + 10'(w)) mmio_rdata_o = en_pad[w*32 +: 32];
      if (waddr == WA_POLAR + 10'(w))  mmio_rdata_o = pol_pad[w*32 +: 32];
    end
  end

  assign msg_on_o    = msg_on_q;
  assign locked_o    = locked_q;
  assign req_log2_o  = req_q;
  assign eff_log2_o  = (alloc_q > req_q) ? req_q : alloc_q;
  assign base_addr_o = addr_q;
  assign base_data_o = data_q;
  assign gap_o       = gap_q;
  assign enable_o    = en_q;
  assign polar_o     = pol_q;
endmodule

// File: rtl/msi_emitter.sv
module msi_emitter
  import msi_pkg::*;
#(
  parameter int NUM_SRC = 50,
  parameter int DELAY_W = 16,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_i,
  input  logic [IDX_W-1:0]   pick_i,
  input  logic [31:0]        base_addr_i,
  input  logic [31:0]        base_data_i,
  input  logic [LOG_W-1:0]   eff_log2_i,
  input  logic [DELAY_W-1:0] gap_i,
  input  logic               msg_ready_i,
  output logic               msg_valid_o,
  output logic [31:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [2:0]         msg_tc_o,
  output logic               done_o,
  output logic [IDX_W-1:0]   done_idx_o
);
  em_state_t          state_q;
  logic [DELAY_W-1:0] cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [31:0]        addr_q, data_q;
  logic [2:0]         tc_q;
  logic [31:0]        low_mask, folded;

  assign low_mask = (32'd1 << eff_log2_i) - 32'd1;
  assign folded   = (base_data_i & ~low_mask) | (32'(pick_i) & low_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EM_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      tc_q    <= '0;
    end else begin
      case (state_q)
        EM_IDLE: if (any_i) begin
          idx_q   <= pick_i;
          addr_q  <= {base_addr_i[31:3], 3'b000};
          tc_q    <= base_addr_i[2:0];
          data_q  <= folded;
          state_q <= EM_SEND;
        end
        EM_SEND: if (msg_ready_i) begin
          if (gap_i == '0) begin
            state_q <= EM_IDLE;
          end else begin
            cnt_q   <= gap_i;
            state_q <= EM_HOLD;
          end
        end
        EM_HOLD: begin
          if (cnt_q <= DELAY_W'(1)) state_q <= EM_IDLE;
          else                      cnt_q   <= cnt_q - DELAY_W'(1);
        end
        default: state_q <= EM_IDLE;
      endcase
    end
  end

  assign msg_valid_o = (state_q == EM_SEND);
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = data_q;
  assign msg_tc_o    = tc_q;
  assign done_o      = (state_q == EM_SEND) && msg_ready_i;
  assign done_idx_o  = idx_q;
endmodule

// File: rtl/msi_irq_gen.sv
module msi_irq_gen
  import msi_pkg::*;
#(
  parameter int NUM_SRC  = 50,
  parameter int DELAY_W  = 16,
  parameter int MAX_LOG2 = 5,
  parameter bit INTA_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               boot_set_i,
  input  logic [2:0]         boot_log2_i,
  input  logic               mmio_we_i,
  input  logic [11:0]        mmio_addr_i,
  input  logic [31:0]        mmio_wdata_i,
  output logic [31:0]        mmio_rdata_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [31:0]        msg_addr_o,
  output logic [31:0]        msg_data_o,
  output logic [2:0]         msg_tc_o,
  output logic               inta_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic               msg_on, locked;
  logic [LOG_W-1:0]   req_log2, eff_log2;
  logic [31:0]        base_addr, base_data;
  logic [DELAY_W-1:0] gap;
  logic [NUM_SRC-1:0] enable, polar, w1c, status, arb_req;
  logic               any, done;
  logic [IDX_W-1:0]   pick, done_idx;

  msi_csr #(.NUM_SRC(NUM_SRC), .DELAY_W(DELAY_W), .MAX_LOG2(MAX_LOG2)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .boot_set_i(boot_set_i), .boot_log2_i(boot_log2_i),
    .mmio_we_i(mmio_we_i), .mmio_addr_i(mmio_addr_i),
    .mmio_wdata_i(mmio_wdata_i), .mmio_rdata_o(mmio_rdata_o),
    .status_i(status), .msg_on_o(msg_on), .locked_o(locked),
    .req_log2_o(req_log2), .eff_log2_o(eff_log2),
    .base_addr_o(base_addr), .base_data_o(base_data), .gap_o(gap),
    .enable_o(enable), .polar_o(polar), .w1c_o(w1c)
  );

  msi_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_i(irq_src_i), .polar_i(polar),
    .w1c_i(w1c), .srv_clr_i(done), .srv_idx_i(done_idx), .status_o(status)
  );

  assign arb_req = status & enable & {NUM_SRC{msg_on}};

  msi_rr_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(arb_req),
    .adv_i(done), .adv_idx_i(done_idx), .any_o(any), .pick_o(pick)
  );

  msi_emitter #(.NUM_SRC(NUM_SRC), .DELAY_W(DELAY_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .any_i(any), .pick_i(pick),
    .base_addr_i(base_addr), .base_data_i(base_data),
    .eff_log2_i(eff_log2), .gap_i(gap), .msg_ready_i(msg_ready_i),
    .msg_valid_o(msg_valid_o), .msg_addr_o(msg_addr_o),
    .msg_data_o(msg_data_o), .msg_tc_o(msg_tc_o),
    .done_o(done), .done_idx_o(done_idx)
  );

  if (INTA_EN) begin : g_inta
    assign inta_o = !msg_on && |(status & enable);
  end else begin : g_no_inta
    assign inta_o = 1'b0;
  end
endmodule

// File: rtl/msi_irq_gen_chk.sv
module msi_irq_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [31:0] msg_addr,
  input logic [31:0] msg_data,
  input logic [2:0]  msg_tc,
  input logic        inta,
  input logic        msg_on,
  input logic        locked,
  input logic [2:0]  req_log2,
  input logic [2:0]  eff_log2
);
  AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_data) && $stable(msg_addr) && $stable(msg_tc)); // R6
  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid); // R8
  AST_SEND_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(msg_on)); // R5
  AST_INTA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    msg_on |-> !inta); // R9
  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(req_log2)); // R10
  AST_ALLOC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    eff_log2 <= req_log2); // R5
endmodule

bind msi_irq_gen msi_irq_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid_o), .msg_ready(msg_ready_i),
  .msg_addr(msg_addr_o), .msg_data(msg_data_o), .msg_tc(msg_tc_o),
  .inta(inta_o), .msg_on(msg_on), .locked(locked),
  .req_log2(req_log2), .eff_log2(eff_log2)
);

// File: tb/msi_irq_gen_test.sv
`timescale 1ns/1ps
module msi_irq_gen_test;
  localparam int N = 50;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic         boot_set = 1'b0;
  logic [2:0]   boot_log2 = '0;
  logic         we = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         msg_valid, msg_ready = 1'b0;
  logic [31:0]  msg_addr, msg_data;
  logic [2:0]   msg_tc;
  logic         inta;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  msi_irq_gen uut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src),
    .boot_set_i(boot_set), .boot_log2_i(boot_log2),
    .mmio_we_i(we), .mmio_addr_i(addr), .mmio_wdata_i(wdata),
    .mmio_rdata_o(rdata), .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data), .msg_tc_o(msg_tc),
    .inta_o(inta)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src = '0; we = 1'b0; boot_set = 1'b0; msg_ready = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int idx);
    src[idx] = 1'b1;
    tick();
    src[idx] = 1'b0;
    tick();
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (msg_valid) begin got = 1'b1; break; end
      tick();
    end
  endtask

  task automatic accept();
    msg_ready = 1'b1;
    tick();
    msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1", "valid", 32'(msg_valid), 32'd0);
    chk("R1", "inta", 32'(inta), 32'd0);
    rd(12'h000, d); chk("R1", "ctrl", d, 32'h500);
    rd(12'h040, d); chk("R1", "status0", d, 32'h0);
    rd(12'h084, d); chk("R1", "enable1", d, 32'h0);
  endtask

  task automatic t_boot_fold();
    logic [31:0] d;
    bit got;
    do_reset();
    boot_log2 = 3'd2; boot_set = 1'b1; tick(); boot_set = 1'b0;
    rd(12'h000, d); chk("R10", "boot 2", d, 32'h200);
    boot_log2 = 3'd7; boot_set = 1'b1; tick(); boot_set = 1'b0;
    rd(12'h000, d); chk("R10", "boot clamp", d, 32'h500);
    boot_log2 = 3'd3; boot_set = 1'b1; tick(); boot_set = 1'b0;
    wr(12'h004, 32'hFEE0_1005);
    boot_log2 = 3'd1; boot_set = 1'b1; tick(); boot_set = 1'b0;
    rd(12'h000, d); chk("R10", "boot after write ignored", d, 32'h300);
    wr(12'h008, 32'hABCD_12F0);
    wr(12'h080, 32'h0000_2000);
    wr(12'h000, 32'h51);
    pulse(13);
    wait_valid(got);
    chk("R5", "valid seen", 32'(got), 32'd1);
    chk("R5", "addr", msg_addr, 32'hFEE0_1000);
    chk("R5", "tc", 32'(msg_tc), 32'd5);
    chk("R5", "data folded into 8", msg_data, 32'hABCD_12F5);
    accept();
    rd(12'h040, d); chk("R5", "status cleared on accept", d, 32'h0);
  endtask

  task automatic t_handshake();
    logic [31:0] d0;
    bit got;
    do_reset();
    wr(12'h008, 32'h1234_5600);
    wr(12'h084, 32'h0000_0100);
    wr(12'h000, 32'h51);
    pulse(40);
    wait_valid(got);
    d0 = msg_data;
    chk("R5", "data source 40 mod 32", d0, 32'h1234_5608);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R6", "valid held", 32'(msg_valid), 32'd1);
      chk("R6", "data stable", msg_data, d0);
    end
    accept();
    chk("R8", "valid low after accept", 32'(msg_valid), 32'd0);
  endtask

  task automatic t_polarity_w1c();
    logic [31:0] d;
    do_reset();
    wr(12'h0C0, 32'h0010_0000);
    src[20] = 1'b1; tick(); tick();
    rd(12'h040, d); chk("R2", "falling-polarity source ignores rise", d, 32'h0);
    src[21] = 1'b1; tick(); tick();
    rd(12'h040, d); chk("R2", "rise sets bit 21", d, 32'h0020_0000);
    src[20] = 1'b0; tick(); tick();
    rd(12'h040, d); chk("R2", "fall sets bit 20", d, 32'h0030_0000);
    src[21] = 1'b0; tick(); tick();
    rd(12'h040, d); chk("R2", "rising-polarity source ignores fall", d, 32'h0030_0000);
    wr(12'h040, 32'h0);
    rd(12'h040, d); chk("R3", "write 0 no effect", d, 32'h0030_0000);
    wr(12'h040, 32'h0010_0000);
    rd(12'h040, d); chk("R3", "w1c clears bit 20", d, 32'h0020_0000);
    src[21] = 1'b1;
    wr(12'h040, 32'h0020_0000);
    tick();
    rd(12'h040, d); chk("R3", "edge wins over clear", d, 32'h0020_0000);
    wr(12'h040, 32'h0020_0000);
    rd(12'h040, d); chk("R3", "clear without edge", d, 32'h0);
    src[21] = 1'b0;
  endtask

  task automatic t_mask();
    logic [31:0] d;
    int seen;
    bit got;
    do_reset();
    wr(12'h000, 32'h51);
    pulse(7);
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      if (msg_valid) seen++;
      tick();
    end
    chk("R4", "masked source sends nothing", 32'(seen), 32'd0);
    rd(12'h040, d); chk("R4", "masked source latched", d, 32'h80);
    wr(12'h080, 32'h80);
    wait_valid(got);
    chk("R4", "message after enabling", 32'(got), 32'd1);
    chk("R4", "data is source 7", msg_data, 32'd7);
    accept();
    rd(12'h040, d); chk("R4", "status cleared", d, 32'h0);
  endtask

  task automatic t_round_robin();
    bit got;
    int exp_a[3] = '{3, 10, 8};
    int exp_b[2] = '{13, 5};
    do_reset();
    wr(12'h080, 32'h0000_0428);
    wr(12'h084, 32'h0000_2100);
    wr(12'h000, 32'h50);
    src[3] = 1'b1; src[10] = 1'b1; src[40] = 1'b1; tick();
    src = '0; tick();
    wr(12'h000, 32'h51);
    for (int k = 0; k < 3; k++) begin
      wait_valid(got);
      chk("R7", "burst order", msg_data, 32'(exp_a[k]));
      accept();
    end
    wr(12'h000, 32'h50);
    src[5] = 1'b1; src[45] = 1'b1; tick();
    src = '0; tick();
    wr(12'h000, 32'h51);
    for (int k = 0; k < 2; k++) begin
      wait_valid(got);
      chk("R7", "wrap order", msg_data, 32'(exp_b[k]));
      accept();
    end
  endtask

  task automatic gap_run(input int dly, input bit prelatched);
    int first, second;
    do_reset();
    wr(12'h00C, 32'(dly));
    wr(12'h080, 32'h6);
    msg_ready = 1'b1;
    if (prelatched) begin
      src[1] = 1'b1; src[2] = 1'b1; tick(); src = '0; tick();
      wr(12'h000, 32'h01);
    end else begin
      wr(12'h000, 32'h01);
      src[1] = 1'b1; src[2] = 1'b1; tick(); src = '0;
    end
    first = -1; second = -1;
    for (int k = 0; k < 40; k++) begin
      if (msg_valid) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
      tick();
    end
    msg_ready = 1'b0;
    chk("R8", $sformatf("sample distance D=%0d", dly), 32'(second - first), 32'(dly + 2));
  endtask

  task automatic t_delay();
    gap_run(3, 1'b1);
    gap_run(0, 1'b0);
  endtask

  task automatic t_inta();
    do_reset();
    wr(12'h080, 32'h80);
    chk("R9", "idle low", 32'(inta), 32'd0);
    pulse(7);
    chk("R9", "pending enabled raises", 32'(inta), 32'd1);
    wr(12'h040, 32'h80);
    chk("R9", "cleared drops", 32'(inta), 32'd0);
    pulse(9);
    chk("R9", "masked pending stays low", 32'(inta), 32'd0);
    pulse(7);
    chk("R9", "raised again", 32'(inta), 32'd1);
    wr(12'h000, 32'h51);
    chk("R9", "messaging on forces low", 32'(inta), 32'd0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    do_reset();
    wr(12'h00B, 32'hCAFE_0001);
    rd(12'h008, d); chk("R11", "low addr bits ignored on write", d, 32'hCAFE_0001);
    rd(12'h009, d); chk("R11", "low addr bits ignored on read", d, 32'hCAFE_0001);
    rd(12'h100, d); chk("R11", "unmapped 0x100", d, 32'h0);
    rd(12'hFFC, d); chk("R11", "unmapped 0xFFC", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    t_boot_fold();
    t_handshake();
    t_polarity_w1c();
    t_mask();
    t_round_robin();
    t_delay();
    t_inta();
    t_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule